// File: doc/BRIEF.md
# Linked Dual Stack Register File

This block holds the working registers of a two-stack processor: a top register T with a 17-level data stack below it, a top register R with a 33-level return stack below it, and a scratch/address register A. Every register and every stack entry is 25 bits wide. Bit 24 is a carry flag that moves with the value on every transfer.

The data stack, T, R and the return stack form one chain. A value can be shifted from the data side toward the return side, or back again, in a single cycle. A 6-bit opcode with a valid strobe selects the register-class operations. A load port writes ALU results, memory reads and literals into T, with a selectable effect on the data stack. A sequencer port pushes a new address into R, for example on a call or an interrupt, or pops the return stack back into R.

Each stack is a ring buffer with a wrapping pointer. Overflow and underflow are not flagged. Pushing past the depth overwrites the oldest entry, and popping past the bottom wraps around to older contents. At most one of the three request sources acts in any cycle.

Top module: `dual_stack_core`

## Requirements
- R1: While `clr` is high at a clock edge, T, R, A and every entry of both stacks become zero. A data-stack pop right after a clear returns zero.
- R2: All 25 bits of a value, carry bit 24 included, are kept unchanged whenever the value moves between T, R, A and the stacks.
- R3: Opcode 0x1A copies T onto the data stack and leaves T unchanged. Opcode 0x1F pops the data stack into T, and the old T is lost. Opcode 0x1B loads T from the data-stack top and pushes the old T.
- R4: Opcode 0x1C pushes the old R onto the return stack, moves T into R, and pops the data stack into T. Opcode 0x18 moves R into T, pushes the old T onto the data stack, and pops the return stack into R.
- R5: Opcode 0x1D copies T into A and pops the data stack into T. Opcode 0x19 copies A into T and pushes the old T. No other action changes A.
- R6: When `ld_en` is high, T takes `ld_data`. With `ld_mode` 1 the old T is pushed onto the data stack. With `ld_mode` 2 the data stack is popped and its top is discarded. With `ld_mode` 0 or 3 the stacks are untouched.
- R7: When the strobe is valid, opcode 0x1E and every opcode outside 0x18 to 0x1F change no register or stack. A load request in the same cycle still takes effect.
- R8: A sequencer request outranks a register-class opcode, and a register-class opcode outranks a load. A request that loses is dropped without effect. When `rs_push` and `rs_pop` are both high, the push wins.
- R9: `rs_push` pushes the old R onto the return stack and loads R with `rs_addr`. `rs_pop` loads R from the return-stack top and pops it. T, the data stack and A do not change.
- R10: The data stack holds 17 entries. After 18 pushes, 17 pops return the newest 17 values, newest first, and an 18th pop wraps back to the newest value.
- R11: The return stack holds 33 entries. After 34 pushes, 33 pops return the newest 33 values, newest first, and a 34th pop wraps back to the newest value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clr | input | 1 | Synchronous clear of all registers and stacks, active high |
| op_valid | input | 1 | Strobe qualifying `opcode` this cycle |
| opcode | input | 6 | Instruction code; the register class is 0x18 to 0x1F |
| ld_en | input | 1 | Load request writing `ld_data` into T |
| ld_mode | input | 2 | Data-stack effect of a load: 0/3 none, 1 push old T, 2 pop |
| ld_data | input | 25 | Value loaded into T |
| rs_push | input | 1 | Sequencer request: push R, then load `rs_addr` into R |
| rs_pop | input | 1 | Sequencer request: pop the return stack into R |
| rs_addr | input | 25 | Address loaded into R on `rs_push` |
| t_out | output | 25 | Current T |
| s_out | output | 25 | Current data-stack top |
| r_out | output | 25 | Current R |
| a_out | output | 25 | Current A |

## Verification
The main contention is between a register-class opcode and a load request in the same cycle, since an ALU result and a stack instruction can both target T. The bench provokes this by strobing the drop opcode while `ld_en` carries a distinct value. It then checks that T and the data-stack top follow the opcode and that the load value appears nowhere. The bench also pairs a sequencer push with a pop request and a duplicate opcode, and checks that only R changes. Each contended cycle is judged on the outputs one cycle later, against values worked out by hand from the requirements.

// File: rtl/dstk_pkg.sv
package dstk_pkg;

  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_POP  = 6'h18;
  localparam logic [OPC_W-1:0] OPC_LDA  = 6'h19;
  localparam logic [OPC_W-1:0] OPC_DUP  = 6'h1A;
  localparam logic [OPC_W-1:0] OPC_OVER = 6'h1B;
  localparam logic [OPC_W-1:0] OPC_PUSH = 6'h1C;
  localparam logic [OPC_W-1:0] OPC_STA  = 6'h1D;
  localparam logic [OPC_W-1:0] OPC_NOP  = 6'h1E;
  localparam logic [OPC_W-1:0] OPC_DROP = 6'h1F;

  localparam logic [1:0] LDM_REPL = 2'd0;
  localparam logic [1:0] LDM_PUSH = 2'd1;
  localparam logic [1:0] LDM_POP  = 2'd2;

  typedef enum logic [1:0] {STK_IDLE, STK_PUSH, STK_POP} stk_act_e;
  typedef enum logic [2:0] {TSRC_HOLD, TSRC_S, TSRC_R, TSRC_A, TSRC_EXT} tsrc_e;
  typedef enum logic [1:0] {RSRC_HOLD, RSRC_T, RSRC_BELOW, RSRC_EXT} rsrc_e;

  typedef struct packed {
    tsrc_e    t_src;
    stk_act_e d_act;
    rsrc_e    r_src;
    stk_act_e r_act;
    logic     a_wr;
  } ctl_t;

  // Register-class opcode that actually moves something (NOP excluded)
  function automatic logic is_stack_op(input logic [OPC_W-1:0] op);
    return (op[5:3] == 3'b011) && (op != OPC_NOP);
  endfunction

endpackage

// File: rtl/dstk_decode.sv
module dstk_decode
  import dstk_pkg::*;
(
  input  logic             op_valid,
  input  logic [OPC_W-1:0] opcode,
  input  logic             ld_en,
  input  logic [1:0]       ld_mode,
  input  logic             rs_push,
  input  logic             rs_pop,
  output ctl_t             ctl,
  output logic             seq_take,
  output logic             op_take,
  output logic             ld_take
);

  always_comb begin
    seq_take = rs_push | rs_pop;
    op_take  = !seq_take && op_valid && is_stack_op(opcode);
    ld_take  = !seq_take && !op_take && ld_en;

    ctl = '{t_src: TSRC_HOLD, d_act: STK_IDLE, r_src: RSRC_HOLD,
            r_act: STK_IDLE, a_wr: 1'b0};

    if (seq_take) begin
      if (rs_push) begin
        ctl.r_act = STK_PUSH;
        ctl.r_src = RSRC_EXT;
      end else begin
        ctl.r_act = STK_POP;
        ctl.r_src = RSRC_BELOW;
      end
    end else if (op_take) begin
      case (opcode)
        OPC_POP: begin
          ctl.t_src = TSRC_R;
          ctl.d_act = STK_PUSH;
          ctl.r_src = RSRC_BELOW;
          ctl.r_act = STK_POP;
        end
        OPC_LDA: begin
          ctl.t_src = TSRC_A;
          ctl.d_act = STK_PUSH;
        end
        OPC_DUP: ctl.d_act = STK_PUSH;
        OPC_OVER: begin
          ctl.t_src = TSRC_S;
          ctl.d_act = STK_PUSH;
        end
        OPC_PUSH: begin
          ctl.t_src = TSRC_S;
          ctl.d_act = STK_POP;
          ctl.r_src = RSRC_T;
          ctl.r_act = STK_PUSH;
        end
        OPC_STA: begin
          ctl.t_src = TSRC_S;
          ctl.d_act = STK_POP;
          ctl.a_wr  = 1'b1;
        end
        OPC_DROP: begin
          ctl.t_src = TSRC_S;
          ctl.d_act = STK_POP;
        end
        default: ;
      endcase
    end else if (ld_take) begin
      ctl.t_src = TSRC_EXT;
      if (ld_mode == LDM_PUSH)     ctl.d_act = STK_PUSH;
      else if (ld_mode == LDM_POP) ctl.d_act = STK_POP;
    end
  end

endmodule

// File: rtl/lifo_ring.sv
module lifo_ring
  import dstk_pkg::*;
#(
  parameter int W     = 25,
  parameter int DEPTH = 17
) (
  input  logic         clk,
  input  logic         clr,
  input  stk_act_e     act,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] top
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] ptr, ptr_nxt, ptr_prv;

  function automatic logic [PW-1:0] ring_up(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  function automatic logic [PW-1:0] ring_dn(input logic [PW-1:0] p);
    return (p == '0) ? LAST : p - PW'(1);
  endfunction

  generate
    if ((1 << PW) == DEPTH) begin : g_pow2
      assign ptr_nxt = ptr + PW'(1);
      assign ptr_prv = ptr - PW'(1);
    end else begin : g_wrap
      assign ptr_nxt = ring_up(ptr);
      assign ptr_prv = ring_dn(ptr);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      ptr <= '0;
    end else begin
      case (act)
        STK_PUSH: begin
          mem[ptr_nxt] <= wdata;
          ptr          <= ptr_nxt;
        end
        STK_POP: ptr <= ptr_prv;
        default: ;
      endcase
    end
  end

  assign top = mem[ptr];

endmodule

// File: rtl/dstk_regs.sv
module dstk_regs
  import dstk_pkg::*;
#(
  parameter int W = 25
) (
  input  logic         clk,
  input  logic         clr,
  input  ctl_t         ctl,
  input  logic [W-1:0] ld_data,
  input  logic [W-1:0] rs_addr,
  input  logic [W-1:0] s_top,
  input  logic [W-1:0] r_below,
  output logic [W-1:0] t_q,
  output logic [W-1:0] r_q,
  output logic [W-1:0] a_q
);

  logic [W-1:0] t_d, r_d;

  always_comb begin
    case (ctl.t_src)
      TSRC_S:   t_d = s_top;
      TSRC_R:   t_d = r_q;
      TSRC_A:   t_d = a_q;
      TSRC_EXT: t_d = ld_data;
      default:  t_d = t_q;
    endcase
    case (ctl.r_src)
      RSRC_T:     r_d = t_q;
      RSRC_BELOW: r_d = r_below;
      RSRC_EXT:   r_d = rs_addr;
      default:    r_d = r_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      t_q <= '0;
      r_q <= '0;
      a_q <= '0;
    end else begin
      t_q <= t_d;
      r_q <= r_d;
      if (ctl.a_wr) a_q <= t_q;
    end
  end

endmodule

// File: rtl/dual_stack_core.sv
module dual_stack_core
  import dstk_pkg::*;
#(
  parameter int DW       = 25,
  parameter int DS_DEPTH = 17,
  parameter int RS_DEPTH = 33
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          op_valid,
  input  logic [5:0]    opcode,
  input  logic          ld_en,
  input  logic [1:0]    ld_mode,
  input  logic [DW-1:0] ld_data,
  input  logic          rs_push,
  input  logic          rs_pop,
  input  logic [DW-1:0] rs_addr,
  output logic [DW-1:0] t_out,
  output logic [DW-1:0] s_out,
  output logic [DW-1:0] r_out,
  output logic [DW-1:0] a_out
);

  ctl_t          ctl;
  logic          seq_take, op_take, ld_take;
  logic [DW-1:0] t_q, r_q, a_q, s_top, r_below;

  dstk_decode u_dec (
    .op_valid (op_valid),
    .opcode   (opcode),
    .ld_en    (ld_en),
    .ld_mode  (ld_mode),
    .rs_push  (rs_push),
    .rs_pop   (rs_pop),
    .ctl      (ctl),
    .seq_take (seq_take),
    .op_take  (op_take),
    .ld_take  (ld_take)
  );

  dstk_regs #(.W(DW)) u_regs (
    .clk     (clk),
    .clr     (clr),
    .ctl     (ctl),
    .ld_data (ld_data),
    .rs_addr (rs_addr),
    .s_top   (s_top),
    .r_below (r_below),
    .t_q     (t_q),
    .r_q     (r_q),
    .a_q     (a_q)
  );

  // Data stack sits below T; it always receives the old T on a push
  lifo_ring #(.W(DW), .DEPTH(DS_DEPTH)) u_dstack (
    .clk   (clk),
    .clr   (clr),
    .act   (ctl.d_act),
    .wdata (t_q),
    .top   (s_top)
  );

  // Return stack sits below R; it always receives the old R on a push
  lifo_ring #(.W(DW), .DEPTH(RS_DEPTH)) u_rstack (
    .clk   (clk),
    .clr   (clr),
    .act   (ctl.r_act),
    .wdata (r_q),
    .top   (r_below)
  );

  assign t_out = t_q;
  assign s_out = s_top;
  assign r_out = r_q;
  assign a_out = a_q;

endmodule

// File: rtl/dual_stack_core_chk.sv
module dual_stack_core_chk
  import dstk_pkg::*;
#(
  parameter int DW = 25
) (
  input logic          clk,
  input logic          clr,
  input logic [5:0]    opcode,
  input logic [DW-1:0] ld_data,
  input logic          rs_push,
  input logic [DW-1:0] rs_addr,
  input logic [DW-1:0] t_out,
  input logic [DW-1:0] s_out,
  input logic [DW-1:0] r_out,
  input logic [DW-1:0] a_out,
  input logic          seq_take,
  input logic          op_take,
  input logic          ld_take
);

  // R1
  clear_zero_chk: assert property (@(posedge clk)
    clr |=> (t_out == '0 && r_out == '0 && a_out == '0 && s_out == '0));

  // R3
  dup_copy_chk: assert property (@(posedge clk) disable iff (clr)
    (op_take && opcode == OPC_DUP) |=> (t_out == $past(t_out) && s_out == $past(t_out)));

  // R3
  over_swap_chk: assert property (@(posedge clk) disable iff (clr)
    (op_take && opcode == OPC_OVER) |=> (t_out == $past(s_out) && s_out == $past(t_out)));

  // R4
  pop_link_chk: assert property (@(posedge clk) disable iff (clr)
    (op_take && opcode == OPC_POP) |=> (t_out == $past(r_out) && s_out == $past(t_out)));

  // R4
  push_link_chk: assert property (@(posedge clk) disable iff (clr)
    (op_take && opcode == OPC_PUSH) |=> (r_out == $past(t_out) && t_out == $past(s_out)));

  // R5
  a_hold_chk: assert property (@(posedge clk) disable iff (clr)
    !(op_take && opcode == OPC_STA) |=> (a_out == $past(a_out)));

  // R5
  a_store_chk: assert property (@(posedge clk) disable iff (clr)
    (op_take && opcode == OPC_STA) |=> (a_out == $past(t_out)));

  // R6
  ld_value_chk: assert property (@(posedge clk) disable iff (clr)
    ld_take |=> (t_out == $past(ld_data)));

  // R8
  one_source_chk: assert property (@(posedge clk) disable iff (clr)
    $onehot0({seq_take, op_take, ld_take}));

  // R9
  seq_t_keep_chk: assert property (@(posedge clk) disable iff (clr)
    seq_take |=> (t_out == $past(t_out) && s_out == $past(s_out)));

  // R9
  rpush_addr_chk: assert property (@(posedge clk) disable iff (clr)
    rs_push |=> (r_out == $past(rs_addr)));

endmodule

bind dual_stack_core dual_stack_core_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .clr      (clr),
  .opcode   (opcode),
  .ld_data  (ld_data),
  .rs_push  (rs_push),
  .rs_addr  (rs_addr),
  .t_out    (t_out),
  .s_out    (s_out),
  .r_out    (r_out),
  .a_out    (a_out),
  .seq_take (seq_take),
  .op_take  (op_take),
  .ld_take  (ld_take)
);

// File: tb/dual_stack_core_tb_top.sv
module dual_stack_core_tb_top;

  logic        clk = 1'b0;
  logic        clr = 1'b1;
  logic        op_valid = 1'b0;
  logic [5:0]  opcode = '0;
  logic        ld_en = 1'b0;
  logic [1:0]  ld_mode = '0;
  logic [24:0] ld_data = '0;
  logic        rs_push = 1'b0;
  logic        rs_pop = 1'b0;
  logic [24:0] rs_addr = '0;
  logic [24:0] t_out, s_out, r_out, a_out;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;

  dual_stack_core dut_i (
    .clk(clk), .clr(clr), .op_valid(op_valid), .opcode(opcode),
    .ld_en(ld_en), .ld_mode(ld_mode), .ld_data(ld_data),
    .rs_push(rs_push), .rs_pop(rs_pop), .rs_addr(rs_addr),
    .t_out(t_out), .s_out(s_out), .r_out(r_out), .a_out(a_out)
  );

  typedef struct packed {
    logic        v;
    logic [5:0]  op;
    logic        le;
    logic [1:0]  lm;
    logic [24:0] ld;
    logic [24:0] et, es, er, ea;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 6'h00, 1'b1, 2'd1, 25'h1000005, 25'h1000005, 25'h0000000, 25'h0000000, 25'h0000000},
    '{1'b0, 6'h00, 1'b1, 2'd1, 25'h0000007, 25'h0000007, 25'h1000005, 25'h0000000, 25'h0000000},
    '{1'b1, 6'h1A, 1'b0, 2'd0, 25'h0000000, 25'h0000007, 25'h0000007, 25'h0000000, 25'h0000000},
    '{1'b1, 6'h17, 1'b1, 2'd2, 25'h0ABCDEF, 25'h0ABCDEF, 25'h1000005, 25'h0000000, 25'h0000000},
    '{1'b1, 6'h1B, 1'b0, 2'd0, 25'h0000000, 25'h1000005, 25'h0ABCDEF, 25'h0000000, 25'h0000000},
    '{1'b1, 6'h1C, 1'b0, 2'd0, 25'h0000000, 25'h0ABCDEF, 25'h1000005, 25'h1000005, 25'h0000000},
    '{1'b1, 6'h1D, 1'b0, 2'd0, 25'h0000000, 25'h1000005, 25'h0000000, 25'h1000005, 25'h0ABCDEF},
    '{1'b1, 6'h19, 1'b0, 2'd0, 25'h0000000, 25'h0ABCDEF, 25'h1000005, 25'h1000005, 25'h0ABCDEF},
    '{1'b1, 6'h18, 1'b0, 2'd0, 25'h0000000, 25'h1000005, 25'h0ABCDEF, 25'h0000000, 25'h0ABCDEF},
    '{1'b1, 6'h1E, 1'b0, 2'd0, 25'h0000000, 25'h1000005, 25'h0ABCDEF, 25'h0000000, 25'h0ABCDEF},
    '{1'b1, 6'h1F, 1'b1, 2'd0, 25'h0123456, 25'h0ABCDEF, 25'h1000005, 25'h0000000, 25'h0ABCDEF},
    '{1'b0, 6'h00, 1'b1, 2'd0, 25'h0123456, 25'h0123456, 25'h1000005, 25'h0000000, 25'h0ABCDEF},
    '{1'b1, 6'h05, 1'b0, 2'd0, 25'h0000000, 25'h0123456, 25'h1000005, 25'h0000000, 25'h0ABCDEF},
    '{1'b0, 6'h00, 1'b1, 2'd3, 25'h1ABCDEF, 25'h1ABCDEF, 25'h1000005, 25'h0000000, 25'h0ABCDEF}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0, 1:  return "R6/R2 load push";
      2:     return "R3 dup";
      3:     return "R7/R6 non-stack op with pop-load";
      4:     return "R3 over";
      5:     return "R4/R2 push to R";
      6:     return "R5 sta";
      7:     return "R5 lda";
      8:     return "R4 pop from R";
      9:     return "R7 nop";
      10:    return "R8 drop beats load";
      11:    return "R6 replace load";
      12:    return "R7 ignored opcode";
      default: return "R6 mode 3 load";
    endcase
  endfunction

  task automatic check(input string tag, input logic [24:0] act, input logic [24:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check4(input string tag, input logic [24:0] et, input logic [24:0] es,
                        input logic [24:0] er, input logic [24:0] ea);
    check({tag, " T"}, t_out, et);
    check({tag, " S"}, s_out, es);
    check({tag, " R"}, r_out, er);
    check({tag, " A"}, a_out, ea);
  endtask

  // Called at a falling edge; returns at the next falling edge with inputs idle
  task automatic cyc(input logic v, input logic [5:0] op, input logic le,
                     input logic [1:0] lm, input logic [24:0] ld,
                     input logic rp, input logic rq, input logic [24:0] ra);
    op_valid = v; opcode = op; ld_en = le; ld_mode = lm; ld_data = ld;
    rs_push = rp; rs_pop = rq; rs_addr = ra;
    @(negedge clk);
    op_valid = 1'b0; ld_en = 1'b0; rs_push = 1'b0; rs_pop = 1'b0;
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check4("R1 reset", '0, '0, '0, '0);
    clr = 1'b0;

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i].v, VEC[i].op, VEC[i].le, VEC[i].lm, VEC[i].ld, 1'b0, 1'b0, '0);
      check4(vec_tag(i), VEC[i].et, VEC[i].es, VEC[i].er, VEC[i].ea);
    end

    // R9: sequencer push loads R with the address
    cyc(1'b0, 6'h00, 1'b0, 2'd0, '0, 1'b1, 1'b0, 25'h0000123);
    check4("R9 rs push", 25'h1ABCDEF, 25'h1000005, 25'h0000123, 25'h0ABCDEF);
    // R8: push beats pop and a concurrent DUP; R2 carry in address
    cyc(1'b1, 6'h1A, 1'b0, 2'd0, '0, 1'b1, 1'b1, 25'h1000456);
    check4("R8 seq beats op", 25'h1ABCDEF, 25'h1000005, 25'h1000456, 25'h0ABCDEF);
    // R9: pops restore R in order
    cyc(1'b0, 6'h00, 1'b0, 2'd0, '0, 1'b0, 1'b1, '0);
    check("R9 rs pop 1", r_out, 25'h0000123);
    cyc(1'b0, 6'h00, 1'b0, 2'd0, '0, 1'b0, 1'b1, '0);
    check("R9 rs pop 2", r_out, 25'h0000000);

    // R10: data stack wrap
    do_clear();
    for (int k = 1; k <= 18; k++) cyc(1'b0, 6'h00, 1'b1, 2'd1, 25'(k), 1'b0, 1'b0, '0);
    check("R10 top after pushes", t_out, 25'd18);
    for (int j = 1; j <= 17; j++) begin
      cyc(1'b1, 6'h1F, 1'b0, 2'd0, '0, 1'b0, 1'b0, '0);
      if (j == 1 || j == 9 || j == 17) check("R10 drop", t_out, 25'(18 - j));
    end
    cyc(1'b1, 6'h1F, 1'b0, 2'd0, '0, 1'b0, 1'b0, '0);
    check("R10 wrap drop", t_out, 25'd17);

    // R11: return stack wrap
    do_clear();
    for (int k = 1; k <= 34; k++) cyc(1'b0, 6'h00, 1'b0, 2'd0, '0, 1'b1, 1'b0, 25'(k));
    check("R11 R after pushes", r_out, 25'd34);
    for (int j = 1; j <= 33; j++) begin
      cyc(1'b0, 6'h00, 1'b0, 2'd0, '0, 1'b0, 1'b1, '0);
      if (j == 1 || j == 33) check("R11 pop", r_out, 25'(34 - j));
    end
    cyc(1'b0, 6'h00, 1'b0, 2'd0, '0, 1'b0, 1'b1, '0);
    check("R11 wrap pop", r_out, 25'd33);

    // R1: clear mid-run wipes stacks too
    cyc(1'b1, 6'h1D, 1'b0, 2'd0, '0, 1'b0, 1'b0, '0);
    do_clear();
    check4("R1 mid clear", '0, '0, '0, '0);
    cyc(1'b1, 6'h1F, 1'b0, 2'd0, '0, 1'b0, 1'b0, '0);
    check("R1 drop after clear", t_out, '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule